// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the column path of an SDRAM controller. It keeps the burst settings written by a mode-register command: a burst length of 1, 2, 4 or 8 beats, or a full page, and a wrap order that is either sequential or interleaved. When a read or write burst starts, it takes the starting column and emits one column address on every clock until the burst is complete.

A fixed-length burst stays inside the aligned block of columns that holds the starting column. Sequential order counts upward from the start offset and wraps inside that block. Interleaved order XORs the start offset with the beat index. A full-page burst walks through every column of the row, wrapping modulo the page size, until it is stopped or replaced by a new burst. A flag marks the final address of a fixed-length burst. A stop input ends any burst early, which is how a full-page burst is closed.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid` and `last_beat` are 0, and the settings are a burst length of 1 with sequential order.
- R2: A cycle with `mode_wr` high loads `mode_key`. Bits 2:0 give the length code (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 gives the order (0 sequential, 1 interleaved). In cycles without `mode_wr` the settings hold.
- R3: The length codes 100, 101 and 110 give a burst of length 1.
- R4: In sequential order with length L, beat b emits the column (start − start mod L) + ((start mod L + b) mod L).
- R5: In interleaved order with length L, beat b emits the column (start − start mod L) + ((start mod L) XOR b).
- R6: A full-page burst emits start, start+1, ... modulo 256 and never raises `last_beat`. It runs until a stop or a new start, and bit 3 has no effect on it.
- R7: `last_beat` is high in exactly the cycle that carries the final address of a fixed-length burst, and in no other cycle.
- R8: The first address appears with `col_valid` high one clock after `start` is sampled. A new address follows on every clock. `col_valid` falls in the cycle after the last beat unless `start` is sampled again.
- R9: A burst uses the settings in effect when its `start` is sampled. A mode write in the same cycle as `start`, or during the burst, applies only to later bursts.
- R10: `stop` sampled while a burst is active makes `col_valid` low in the next cycle. `stop` has no effect while idle.
- R11: `start` sampled during an active burst begins the new burst at once, and takes priority over a `stop` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_key | input | 4 | Mode field taken from the address bus |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | Starting column of the burst |
| stop | input | 1 | End the active burst |
| col_valid | output | 1 | `col_addr` carries a burst beat |
| col_addr | output | 8 | Column address of the current beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions assume that `start`, `stop` and `mode_wr` are clean single-bit levels that are sampled once per clock. They place no restriction on how these three combine: a start may come during a burst or together with a stop or a mode write. The stimulus exercises these overlaps on purpose, including a start with a stop, a start with a mode write, and a mode write in the middle of a burst. It drives every input at the falling edge, so each rising edge sees stable values, and after reset it always leaves a cycle with no start or stop. A behavioural model built on queues predicts every output for each clock.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    parameter int CFG_COL_W = 8;
    parameter int CFG_KEY_W = 4;

    typedef struct packed {
        logic                 full_page;
        logic                 interleave;
        logic [CFG_COL_W-1:0] wrap_mask;
    } burst_cfg_t;

    // Length code in bits 2:0, order in bit 3.
    function automatic burst_cfg_t decode_key(logic [CFG_KEY_W-1:0] key);
        burst_cfg_t c;
        c.full_page  = 1'b0;
        c.interleave = key[3];
        c.wrap_mask  = '0;
        unique case (key[2:0])
            3'b001:  c.wrap_mask = CFG_COL_W'(1);
            3'b010:  c.wrap_mask = CFG_COL_W'(3);
            3'b011:  c.wrap_mask = CFG_COL_W'(7);
            3'b111: begin
                c.full_page  = 1'b1;
                c.interleave = 1'b0;
                c.wrap_mask  = '1;
            end
            default: c.wrap_mask = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_col_pkg::*;
#(
    parameter int KEY_W = CFG_KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key,
    output burst_cfg_t       cfg
);

    burst_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = decode_key(key);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{full_page: 1'b0, interleave: 1'b0, wrap_mask: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    a_r6_full_is_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.full_page |-> (!cfg_q.interleave && (&cfg_q.wrap_mask)));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;
    assign sum = base + beat;

    // Bits outside the wrap mask keep the starting column; bits inside
    // follow either the running sum or the XOR with the beat index.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? (interleave ? (base[i] ^ beat[i]) : sum[i])
                                : base[i];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = CFG_COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_cfg_t       cfg,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic             valid,
    output logic [COL_W-1:0] col,
    output logic             last
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             last;
        logic             full;
        logic             il;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [COL_W-1:0] map_col;
    logic [COL_W-1:0] beat_inc;

    assign beat_inc = st_q.beat + ONE;

    burst_col_map #(.COL_W(COL_W)) map_i (
        .base       (st_d.base),
        .beat       (st_d.beat),
        .mask       (st_d.mask),
        .interleave (st_d.il),
        .col        (map_col)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.full   = cfg.full_page;
            st_d.il     = cfg.interleave;
            st_d.mask   = cfg.wrap_mask;
            st_d.base   = start_col;
            st_d.beat   = '0;
            st_d.last   = !cfg.full_page && (cfg.wrap_mask == '0);
        end else if (st_q.active && (stop || st_q.last)) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
            st_d.full   = 1'b0;
        end else if (st_q.active) begin
            st_d.beat = beat_inc;
            st_d.last = !st_q.full && (beat_inc == st_q.mask);
        end
        st_d.col = map_col;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.active;
    assign col   = st_q.col;
    assign last  = st_q.last;

    a_r8_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && col == $past(start_col)));

    a_r7_last_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    a_r8_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && !start) |=> !valid);

    a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && stop && !start) |=> !valid);

    a_r8_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last && !stop && !start) |=> valid);

    a_r6_full_never_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> !last);

    a_r4_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last && !stop && !start) |=>
            ((col & ~st_q.mask) == ($past(col) & ~st_q.mask)));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = CFG_COL_W,
    parameter int KEY_W = CFG_KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [KEY_W-1:0] mode_key,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             last_beat
);

    burst_cfg_t cfg;

    burst_mode_reg #(.KEY_W(KEY_W)) mode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mode_wr),
        .key   (mode_key),
        .cfg   (cfg)
    );

    burst_col_seq #(.COL_W(COL_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .start     (start),
        .start_col (start_col),
        .stop      (stop),
        .valid     (col_valid),
        .col       (col_addr),
        .last      (last_beat)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!col_valid && !last_beat));

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_key = '0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       stop = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       last_beat;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_key(mode_key),
        .start(start), .start_col(start_col), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .last_beat(last_beat)
    );

    // Reference model
    int    m_len = 1;    // 0 means full page
    bit    m_il  = 0;
    bit    e_valid = 0;
    bit    e_last  = 0;
    bit    e_full  = 0;
    int    e_col   = 0;
    int    e_q[$];
    string e_tag = "R4";

    always @(posedge clk) begin
        int old_len;
        bit old_il;
        old_len = m_len;
        old_il  = m_il;
        if (!rst_n) begin
            m_len = 1; m_il = 0; e_valid = 0; e_last = 0; e_full = 0;
            e_q.delete();
        end else begin
            if (start) begin
                e_q.delete();
                e_valid = 1;
                if (old_len == 0) begin
                    e_full = 1; e_col = int'(start_col); e_last = 0; e_tag = "R6";
                end else begin
                    int s, off, base;
                    s = int'(start_col);
                    off = s % old_len;
                    base = s - off;
                    e_full = 0;
                    e_tag = old_il ? "R5" : "R4";
                    for (int b = 0; b < old_len; b++)
                        e_q.push_back(old_il ? base + (off ^ b) : base + ((off + b) % old_len));
                    e_col = e_q.pop_front();
                    e_last = (e_q.size() == 0);
                end
            end else if (e_valid && (stop || e_last)) begin
                e_valid = 0; e_last = 0; e_full = 0; e_q.delete();
            end else if (e_valid) begin
                if (e_full) e_col = (e_col + 1) % 256;
                else begin
                    e_col = e_q.pop_front();
                    e_last = (e_q.size() == 0);
                end
            end
            if (mode_wr) begin
                case (mode_key[2:0])
                    3'd1: m_len = 2;
                    3'd2: m_len = 4;
                    3'd3: m_len = 8;
                    3'd7: m_len = 0;
                    default: m_len = 1;
                endcase
                m_il = mode_key[3] && (m_len != 0);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R8 valid, R7 last, R4/R5/R6 address)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8", int'(col_valid), int'(e_valid));
            check("R7", int'(last_beat), int'(e_last));
            if (e_valid) check(e_tag, int'(col_addr), e_col);
        end
    end

    task automatic write_mode(logic [3:0] k);
        @(negedge clk); mode_wr = 1'b1; mode_key = k;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic pulse_start(logic [7:0] c);
        @(negedge clk); start = 1'b1; start_col = c;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_burst(logic [7:0] c, int exp_len, string req);
        int n = 0;
        pulse_start(c);
        while (col_valid && n < 300) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp_len);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(col_valid), 0);
        check("R1", int'(last_beat), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default length 1
        run_burst(8'h37, 1, "R1");

        // R2/R3/R4/R5: every code with both orders, several start columns
        for (int code = 0; code < 7; code++) begin
            for (int t = 0; t < 2; t++) begin
                int len;
                len = (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 1;
                write_mode({t[0], code[2:0]});
                run_burst(8'h00, len, (code >= 4) ? "R3" : "R2");
                run_burst(8'h05, len, (code >= 4) ? "R3" : "R2");
                run_burst(8'hFE, len, (code >= 4) ? "R3" : "R2");
                run_burst(8'h7B, len, (code >= 4) ? "R3" : "R2");
            end
        end

        // R6: full page, interleave bit set, wraps past 255, then stop
        write_mode(4'b1111);
        pulse_start(8'hFC);
        repeat (300) @(negedge clk);
        check("R6", int'(col_valid), 1);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        check("R10", int'(col_valid), 0);

        // R10: stop while idle has no effect on the next burst
        write_mode(4'b0011);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        run_burst(8'h12, 8, "R10");
        // R10: early stop of a fixed burst
        pulse_start(8'h20);
        @(negedge clk);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        check("R10", int'(col_valid), 0);

        // R9: mode write during a burst applies to the next one only
        pulse_start(8'h43);
        mode_wr = 1'b1; mode_key = 4'b0001; @(negedge clk); mode_wr = 1'b0;
        repeat (8) @(negedge clk);
        run_burst(8'h43, 2, "R9");
        // R9: mode write in the same cycle as start
        @(negedge clk);
        start = 1'b1; start_col = 8'h09; mode_wr = 1'b1; mode_key = 4'b1011;
        @(negedge clk); start = 1'b0; mode_wr = 1'b0;
        repeat (3) @(negedge clk);
        run_burst(8'h09, 8, "R9");

        // R11: restart mid burst, and start beating stop
        pulse_start(8'h60);
        @(negedge clk);
        start = 1'b1; start_col = 8'hA5; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        check("R11", int'(col_valid), 1);
        repeat (10) @(negedge clk);
        check("R11", int'(col_valid), 0);

        // R1: reset in the middle of a burst
        pulse_start(8'h10);
        rst_n = 1'b0; @(negedge clk);
        check("R1", int'(col_valid), 0);
        rst_n = 1'b1; @(negedge clk);
        run_burst(8'h10, 1, "R1");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule